// File: doc/BRIEF.md
# High-Resolution Monochrome Overlay Serializer

This block turns one byte of palette output per normal pixel into a faster stream of narrow pixels for monochrome or grey-level displays. It runs in the fast serial clock domain. On the first fast clock of each normal pixel it samples a video byte and a cursor byte and lays the cursor over the video one bit-pair at a time. It then shifts the merged byte out, most significant symbol first, as 1-bit, 2-bit or 4-bit symbols. A single-bit mode that keeps only the even bits is also provided, for feeding a 4-bit grey pattern into a 1-bit stream.

A pixel strobe rises on the fast clock that carries the first symbol of each pixel, so that downstream serializers or a DAC can align to pixel boundaries. The path is live only while the high-resolution flag is set and the output-select field holds the high-resolution code. Otherwise every output is held at zero and the shift sequence is abandoned.

Top module: `hrmono_serializer`

## Requirements
- R1: The path is active only when `hires_en` is 1 and `out_sel` equals 2'b10. After any clock edge at which it is inactive, `ser_data`, `pix_strobe` and `merged_byte` are all zero and no partly sent pixel is resumed.
- R2: For bit-pair p (bits 2p+1:2p), when cursor bit 2p is 0 the merged pair equals the video pair, whatever cursor bit 2p+1 holds.
- R3: For bit-pair p, when cursor bit 2p is 1 both merged bits equal cursor bit 2p+1, so cursor pair 01 gives 00 and cursor pair 11 gives 11.
- R4: With `width_sel` = 2'b00 a pixel lasts 8 fast clocks, and `ser_data[0]` carries merged bits 7 down to 0 in that order, with `ser_data[3:1]` at zero.
- R5: With `width_sel` = 2'b01 a pixel lasts 4 fast clocks, and `ser_data[0]` carries merged bits 6, 4, 2, 0 in that order, with `ser_data[3:1]` at zero.
- R6: With `width_sel` = 2'b10 a pixel lasts 4 fast clocks, and `ser_data[1:0]` carries merged bits 7:6, 5:4, 3:2, 1:0 in that order, with `ser_data[3:2]` at zero.
- R7: With `width_sel` = 2'b11 a pixel lasts 2 fast clocks, and `ser_data` carries merged bits 7:4 and then 3:0.
- R8: While active, a new pixel's `vid_byte` and `cur_byte` are sampled at the first active edge and at the edge that follows the last symbol of the previous pixel. `pix_strobe` is 1 for exactly the cycle after that edge. `merged_byte` shows the merged byte from that edge until the next pixel starts.
- R9: `width_sel` is sampled only at pixel starts, so changing it partway through a pixel changes neither that pixel's symbols nor its length.
- R10: When the path is reactivated after being inactive, the first active edge starts a fresh pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast serial clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hires_en | input | 1 | High-resolution mode flag |
| out_sel | input | 2 | Output-select field; 2'b10 selects this path |
| width_sel | input | 2 | Serial symbol format (00 bit, 01 even bits, 10 pair, 11 nibble) |
| vid_byte | input | 8 | Blue palette data for the current normal pixel |
| cur_byte | input | 8 | Cursor data, four control pairs |
| ser_data | output | 4 | Current fast-pixel symbol, right-aligned |
| pix_strobe | output | 1 | High on the first symbol cycle of each normal pixel |
| merged_byte | output | 8 | Cursor-merged byte of the pixel being sent |

## Verification
The hardest cases to reach are those where control inputs move off the pixel grid: a width change or a deactivation partway through a pixel. Each of these must leave the sequence already under way intact or abandon it cleanly. The stimulus reaches them with phases that change `width_sel` on every fast clock and toggle the enable and output-select at random. A queue-based model refills only when it runs empty, so every off-grid change is compared on the cycle it lands. In each width phase the cursor cycles through fixed patterns that hold all four pair codes, and through the all-forced cases.

// File: rtl/hrmono_pkg.sv
package hrmono_pkg;
  localparam int PIX_W = 8;
  localparam int SYM_W = 4;
  localparam int NPAIR = PIX_W / 2;
  localparam int CNT_W = $clog2(PIX_W);

  typedef enum logic [1:0] {
    W_BIT  = 2'b00,
    W_EVEN = 2'b01,
    W_PAIR = 2'b10,
    W_NIB  = 2'b11
  } width_e;

  localparam logic [1:0] SEL_HIRES = 2'b10;

  // cursor control pair: low bit selects, high bit is the forced value
  function automatic logic [1:0] merge_pair(logic [1:0] v, logic [1:0] c);
    return c[0] ? {2{c[1]}} : v;
  endfunction

  function automatic int unsigned step_bits(width_e w);
    case (w)
      W_NIB:   return 4;
      W_PAIR:  return 2;
      default: return 1;
    endcase
  endfunction

  // index of the last symbol of a pixel
  function automatic logic [CNT_W-1:0] sym_last(width_e w);
    case (w)
      W_BIT:   return CNT_W'(PIX_W - 1);
      W_EVEN:  return CNT_W'(NPAIR - 1);
      W_PAIR:  return CNT_W'(PIX_W / 2 - 1);
      default: return CNT_W'(PIX_W / 4 - 1);
    endcase
  endfunction

  // shift-register image at pixel start
  function automatic logic [PIX_W-1:0] pack_load(logic [PIX_W-1:0] m, width_e w);
    logic [PIX_W-1:0] r;
    r = '0;
    if (w == W_EVEN) begin
      for (int i = 0; i < NPAIR; i++) r[PIX_W-1-i] = m[PIX_W-2-2*i];
    end else begin
      r = m;
    end
    return r;
  endfunction
endpackage

// File: rtl/hrmono_merge.sv
module hrmono_merge
  import hrmono_pkg::*;
(
  input  logic [PIX_W-1:0] vid,
  input  logic [PIX_W-1:0] cur,
  output logic [PIX_W-1:0] mix
);
  for (genvar p = 0; p < NPAIR; p++) begin : g_pair
    assign mix[2*p+1:2*p] = merge_pair(vid[2*p+1:2*p], cur[2*p+1:2*p]);
  end
endmodule

// File: rtl/hrmono_pacer.sv
module hrmono_pacer
  import hrmono_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   active,
  input  width_e width_now,
  output logic   load_evt
);
  logic [CNT_W-1:0] cnt_q;

  assign load_evt = active && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!active)  cnt_q <= '0;
    else if (load_evt) cnt_q <= sym_last(width_now);
    else               cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/hrmono_shifter.sv
module hrmono_shifter
  import hrmono_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             load_evt,
  input  width_e           width_in,
  input  logic [PIX_W-1:0] mix,
  output logic [SYM_W-1:0] ser_data,
  output logic             strobe,
  output logic [PIX_W-1:0] merged
);
  logic [PIX_W-1:0] sh_q;
  width_e           width_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q    <= '0;
      width_q <= W_BIT;
      strobe  <= 1'b0;
      merged  <= '0;
    end else if (!active) begin
      sh_q   <= '0;
      strobe <= 1'b0;
      merged <= '0;
    end else if (load_evt) begin
      sh_q    <= pack_load(mix, width_in);
      width_q <= width_in;
      merged  <= mix;
      strobe  <= 1'b1;
    end else begin
      sh_q   <= sh_q << step_bits(width_q);
      strobe <= 1'b0;
    end
  end

  assign ser_data = SYM_W'(sh_q >> (PIX_W - step_bits(width_q)));
endmodule

// File: rtl/hrmono_serializer.sv
module hrmono_serializer
  import hrmono_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hires_en,
  input  logic [1:0]       out_sel,
  input  logic [1:0]       width_sel,
  input  logic [PIX_W-1:0] vid_byte,
  input  logic [PIX_W-1:0] cur_byte,
  output logic [SYM_W-1:0] ser_data,
  output logic             pix_strobe,
  output logic [PIX_W-1:0] merged_byte
);
  logic             active;
  logic             load_evt;
  logic [PIX_W-1:0] mix;
  width_e           wsel;

  assign active = hires_en && (out_sel == SEL_HIRES);
  assign wsel   = width_e'(width_sel);

  hrmono_merge u_merge (
    .vid (vid_byte),
    .cur (cur_byte),
    .mix (mix)
  );

  hrmono_pacer u_pacer (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .width_now (wsel),
    .load_evt  (load_evt)
  );

  hrmono_shifter u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .load_evt (load_evt),
    .width_in (wsel),
    .mix      (mix),
    .ser_data (ser_data),
    .strobe   (pix_strobe),
    .merged   (merged_byte)
  );
endmodule

// File: rtl/hrmono_checker.sv
module hrmono_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       hires_en,
  input logic [1:0] out_sel,
  input logic [7:0] vid_byte,
  input logic [7:0] cur_byte,
  input logic       load_evt,
  input logic [3:0] ser_data,
  input logic       pix_strobe,
  input logic [7:0] merged_byte
);
  logic path_on;
  assign path_on = hires_en && (out_sel == 2'b10);

  a_r1_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !path_on |=> (ser_data == 4'd0 && !pix_strobe && merged_byte == 8'd0));

  a_r8_strobe_follows_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> pix_strobe);

  a_r8_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    pix_strobe |=> !pix_strobe);

  a_r8_merged_held: assert property (@(posedge clk) disable iff (!rst_n)
    (path_on && !load_evt) |=> $stable(merged_byte));

  a_r3_forced_top_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && cur_byte[6]) |=> (merged_byte[7:6] == {2{$past(cur_byte[7])}}));

  a_r2_pass_low_pair: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !cur_byte[0]) |=> (merged_byte[1:0] == $past(vid_byte[1:0])));
endmodule

bind hrmono_serializer hrmono_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hires_en    (hires_en),
  .out_sel     (out_sel),
  .vid_byte    (vid_byte),
  .cur_byte    (cur_byte),
  .load_evt    (load_evt),
  .ser_data    (ser_data),
  .pix_strobe  (pix_strobe),
  .merged_byte (merged_byte)
);

// File: tb/sim_hrmono_serializer.sv
`timescale 1ns/1ps
module sim_hrmono_serializer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       hires_en = 1'b0;
  logic [1:0] out_sel = 2'b00;
  logic [1:0] width_sel = 2'b00;
  logic [7:0] vid_byte = 8'h00;
  logic [7:0] cur_byte = 8'h00;
  logic [3:0] ser_data;
  logic       pix_strobe;
  logic [7:0] merged_byte;

  always #10 clk = ~clk;

  hrmono_serializer u0 (
    .clk(clk), .rst_n(rst_n), .hires_en(hires_en), .out_sel(out_sel),
    .width_sel(width_sel), .vid_byte(vid_byte), .cur_byte(cur_byte),
    .ser_data(ser_data), .pix_strobe(pix_strobe), .merged_byte(merged_byte)
  );

  int vectors = 0;
  int errors = 0;
  bit done = 0;
  string ctx = "R1";

  int symq[$];
  int exp_ser = 0;
  int exp_stb = 0;
  int exp_mrg = 0;

  logic [7:0] pat [7] = '{8'h00, 8'h55, 8'hAA, 8'hFF, 8'h1B, 8'hE4, 8'h00};

  // bitwise restatement of the overlay rule (R2, R3)
  function automatic int overlay(int v, int c);
    int r = 0;
    for (int i = 0; i < 8; i++) begin
      int lo = (i / 2) * 2;
      int b;
      if (((c >> lo) & 1) == 1) b = (c >> (lo + 1)) & 1;
      else                      b = (v >> i) & 1;
      r = r | (b << i);
    end
    return r;
  endfunction

  task automatic model_edge();
    if (!(hires_en == 1'b1 && out_sel == 2'b10)) begin
      symq.delete();
      exp_ser = 0; exp_stb = 0; exp_mrg = 0;
    end else begin
      if (symq.size() == 0) begin
        int m = overlay(vid_byte, cur_byte);
        exp_mrg = m;
        exp_stb = 1;
        case (width_sel)
          2'b00: for (int b = 7; b >= 0; b--) symq.push_back((m >> b) & 1);
          2'b01: for (int b = 6; b >= 0; b -= 2) symq.push_back((m >> b) & 1);
          2'b10: for (int k = 3; k >= 0; k--) symq.push_back((m >> (2 * k)) & 3);
          default: begin symq.push_back(m >> 4); symq.push_back(m & 15); end
        endcase
      end else begin
        exp_stb = 0;
      end
      exp_ser = symq.pop_front();
    end
  endtask

  task automatic compare();
    bit bad = 0;
    vectors++;
    if (int'(ser_data) != exp_ser) begin
      $display("FAIL %s ser_data: actual %0h expected %0h", ctx, ser_data, exp_ser);
      bad = 1;
    end
    if (int'(pix_strobe) != exp_stb) begin
      $display("FAIL R8 (%s) pix_strobe: actual %0d expected %0d", ctx, pix_strobe, exp_stb);
      bad = 1;
    end
    if (int'(merged_byte) != exp_mrg) begin
      $display("FAIL R2 R3 (%s) merged_byte: actual %0h expected %0h", ctx, merged_byte, exp_mrg);
      bad = 1;
    end
    if (bad) errors++;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    #5;
    compare();
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    ctx = "R1 reset";
    compare();
    rst_n = 1'b1;

    // R1: wrong select code, then flag cleared
    ctx = "R1";
    hires_en = 1'b1; out_sel = 2'b01;
    for (int i = 0; i < 20; i++) begin
      vid_byte = 8'($urandom); cur_byte = 8'($urandom); step();
    end
    hires_en = 1'b0; out_sel = 2'b10;
    for (int i = 0; i < 20; i++) begin
      vid_byte = 8'($urandom); cur_byte = 8'($urandom); step();
    end
    hires_en = 1'b1; out_sel = 2'b11;
    for (int i = 0; i < 10; i++) step();

    // R4..R7: every width with all cursor-pair codes
    for (int w = 0; w < 4; w++) begin
      case (w)
        0: ctx = "R4";
        1: ctx = "R5";
        2: ctx = "R6";
        default: ctx = "R7";
      endcase
      hires_en = 1'b0; step();
      width_sel = 2'(w); hires_en = 1'b1; out_sel = 2'b10;
      for (int i = 0; i < 140; i++) begin
        vid_byte = 8'($urandom);
        cur_byte = (i % 7 == 6) ? 8'($urandom) : pat[i % 7];
        step();
      end
    end

    // R9: width moves on every fast clock
    ctx = "R9";
    for (int i = 0; i < 200; i++) begin
      width_sel = 2'($urandom); vid_byte = 8'($urandom); cur_byte = 8'($urandom);
      step();
    end

    // R10: path toggled off and on at random points
    ctx = "R10";
    for (int i = 0; i < 300; i++) begin
      if (i % 40 == 0) width_sel = 2'($urandom);
      hires_en = ($urandom % 5) != 0;
      out_sel = (($urandom % 6) == 0) ? 2'b00 : 2'b10;
      vid_byte = 8'($urandom); cur_byte = 8'($urandom);
      step();
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule